// File: doc/BRIEF.md
# Cascaded Clock-Enable Divider Tree

This block derives four strobe outputs from a single system clock. Each strobe is a one-cycle enable pulse in that clock's domain. No clock is gated or generated.

- The processor-rate strobe divides the system clock by a power of two, picked by a 3-bit code.
- The first variable divider divides the system clock by 1 to 16.
- The second variable divider counts strobes from the first and divides them by 1 to 16. Its overall period is therefore the product of the two ratios.
- The third variable divider is 8 bits wide and divides by 1 to 256. It counts strobes from one of four inputs: the system clock itself, the first divider, the second divider, or an externally supplied double-rate enable.

All ratios and the source code come in on steady register-style inputs. A divider captures its ratio, and the third divider also captures its source, only at its own terminal count or at reset. A change made while a divider is running therefore finishes the current period unchanged. The next period uses the new setting.

Top module: `cdt_clock_tree`

## Requirements
- R1: With processor-rate code s (0 to 7), `cpu_en_o` pulses every 2^s system-clock cycles.
- R2: `vd1_en_o` pulses every N1 = `vd1_m1_i`+1 cycles, for every N1 from 1 to 16.
- R3: `vd2_en_o` pulses once per N2 = `vd2_m1_i`+1 pulses of `vd1_en_o`, so every N1*N2 cycles.
- R4: `vd3_en_o` pulses once per N3 = `vd3_m1_i`+1 pulses of its selected source, for N3 from 1 to 256.
- R5: The 2-bit `vd3_src_i` selects the third divider's source: 0 is every system cycle, 1 is `vd1_en_o`, 2 is `vd2_en_o`, 3 is `dbl_en_i`.
- R6: With a ratio of 1, a divider's output repeats each qualifying input pulse one cycle later. With the first divider's ratio at 1, `vd1_en_o` is high on every cycle.
- R7: Every output pulse lasts one cycle when the ratio is above 1. A pulse is produced only on a cycle that follows a qualifying input pulse.
- R8: A ratio or source change takes effect only at the next terminal count. The period in progress completes with the old setting, and the following period uses the new setting.
- R9: A synchronous reset (`rst`, active high) holds all outputs low and clears every counter. The first pulse after reset is released comes after one full period, counted from the first clock edge with reset low: 2^s cycles for the processor-rate strobe, N1 for the first divider, N1*N2+1 for the second, and N3, N1*N3+1 or N1*N2*N3+2 for the third with sources 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dbl_en_i | input | 1 | Double-rate enable, source 3 of the third divider |
| cpu_sel_i | input | 3 | Processor-rate code s, period 2^s |
| vd1_m1_i | input | 4 | First divider ratio minus one |
| vd2_m1_i | input | 4 | Second divider ratio minus one |
| vd3_m1_i | input | 8 | Third divider ratio minus one |
| vd3_src_i | input | 2 | Third divider source code |
| cpu_en_o | output | 1 | Processor-rate strobe |
| vd1_en_o | output | 1 | First divider strobe |
| vd2_en_o | output | 1 | Second divider strobe |
| vd3_en_o | output | 1 | Third divider strobe |

## Verification
Every strobe is registered. A divider fed directly by the system clock pulses after the edge on which it reaches its count. Each registered stage in the cascade adds one more cycle of delay, which gives the +1 and +2 terms of R9.

After every configuration change, the bench applies a one-cycle reset. From the first edge with reset low, it counts falling edges until the first pulse and compares that count with the R9 latency. It then counts falling edges up to the next pulse and compares that interval with the period from R1 to R5.

The R8 checks skip the reset on purpose. They change a setting on the falling edge right after a pulse and expect one more period at the old setting. For the source change, they discard the boundary period, whose phase is undetermined, and compare the period after it.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int CPU_SEL_W = 3;
  localparam int CPU_CNT_W = (1 << CPU_SEL_W) - 1;
  localparam int SRC_SEL_W = 2;
  localparam int NUM_SRC   = 1 << SRC_SEL_W;

  typedef enum logic [SRC_SEL_W-1:0] {
    SRC_SYS = 2'd0,
    SRC_VD1 = 2'd1,
    SRC_VD2 = 2'd2,
    SRC_DBL = 2'd3
  } src_e;

  // Terminal count for the processor-rate strobe: 2^sel - 1
  function automatic logic [CPU_CNT_W-1:0] cpu_ratio_m1(input logic [CPU_SEL_W-1:0] sel);
    logic [CPU_CNT_W:0] p;
    p = {{CPU_CNT_W{1'b0}}, 1'b1} << sel;
    p = p - {{CPU_CNT_W{1'b0}}, 1'b1};
    return p[CPU_CNT_W-1:0];
  endfunction
endpackage

// File: rtl/cdt_div_cell.sv
module cdt_div_cell #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] ratio_m1_i,
  output logic         tc_o,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] act_q;
  logic         at_end;

  assign at_end = (cnt_q == act_q);
  assign tc_o   = en_i & at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      act_q   <= ratio_m1_i;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= tc_o;
      if (tc_o) begin
        cnt_q <= '0;
        act_q <= ratio_m1_i;
      end else if (en_i) begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  AST_PULSE_QUALIFIED: assert property (@(posedge clk) disable iff (rst) pulse_o |-> $past(en_i)); // R7
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst) cnt_q <= act_q); // R2
  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (rst) !tc_o |=> $stable(act_q)); // R8
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (rst) tc_o |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/cdt_cpu_div.sv
module cdt_cpu_div
  import cdt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CPU_SEL_W-1:0] sel_i,
  output logic                 en_o
);
  logic [CPU_CNT_W-1:0] ratio_m1;
  logic                 cpu_tc;

  assign ratio_m1 = cpu_ratio_m1(sel_i);

  cdt_div_cell #(.W(CPU_CNT_W)) u_cell (
    .clk        (clk),
    .rst        (rst),
    .en_i       (1'b1),
    .ratio_m1_i (ratio_m1),
    .tc_o       (cpu_tc),
    .pulse_o    (en_o)
  );

  AST_CPU_TC_TO_STROBE: assert property (@(posedge clk) disable iff (rst) cpu_tc |=> en_o); // R1
endmodule

// File: rtl/cdt_var_div3.sv
module cdt_var_div3
  import cdt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   src_vec_i,
  input  logic [SRC_SEL_W-1:0] src_sel_i,
  input  logic [W-1:0]         ratio_m1_i,
  output logic                 en_o
);
  logic [SRC_SEL_W-1:0] act_src_q;
  logic                 sel_en;
  logic                 vd3_tc;

  assign sel_en = src_vec_i[act_src_q];

  always_ff @(posedge clk) begin
    if (rst)         act_src_q <= src_sel_i;
    else if (vd3_tc) act_src_q <= src_sel_i;
  end

  cdt_div_cell #(.W(W)) u_cell (
    .clk        (clk),
    .rst        (rst),
    .en_i       (sel_en),
    .ratio_m1_i (ratio_m1_i),
    .tc_o       (vd3_tc),
    .pulse_o    (en_o)
  );

  AST_SRC_HELD: assert property (@(posedge clk) disable iff (rst) !vd3_tc |=> $stable(act_src_q)); // R8
  AST_SRC_QUALIFIED: assert property (@(posedge clk) disable iff (rst) en_o |-> $past(src_vec_i[act_src_q])); // R5
endmodule

// File: rtl/cdt_clock_tree.sv
module cdt_clock_tree
  import cdt_pkg::*;
#(
  parameter int VD1_W = 4,
  parameter int VD2_W = 4,
  parameter int VD3_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dbl_en_i,
  input  logic [CPU_SEL_W-1:0] cpu_sel_i,
  input  logic [VD1_W-1:0]     vd1_m1_i,
  input  logic [VD2_W-1:0]     vd2_m1_i,
  input  logic [VD3_W-1:0]     vd3_m1_i,
  input  logic [SRC_SEL_W-1:0] vd3_src_i,
  output logic                 cpu_en_o,
  output logic                 vd1_en_o,
  output logic                 vd2_en_o,
  output logic                 vd3_en_o
);
  logic               vd1_tc;
  logic               vd2_tc;
  logic [NUM_SRC-1:0] src_vec;

  always_comb begin
    src_vec          = '0;
    src_vec[SRC_SYS] = 1'b1;
    src_vec[SRC_VD1] = vd1_en_o;
    src_vec[SRC_VD2] = vd2_en_o;
    src_vec[SRC_DBL] = dbl_en_i;
  end

  cdt_cpu_div u_cpu (
    .clk   (clk),
    .rst   (rst),
    .sel_i (cpu_sel_i),
    .en_o  (cpu_en_o)
  );

  cdt_div_cell #(.W(VD1_W)) u_vd1 (
    .clk        (clk),
    .rst        (rst),
    .en_i       (1'b1),
    .ratio_m1_i (vd1_m1_i),
    .tc_o       (vd1_tc),
    .pulse_o    (vd1_en_o)
  );

  cdt_div_cell #(.W(VD2_W)) u_vd2 (
    .clk        (clk),
    .rst        (rst),
    .en_i       (vd1_en_o),
    .ratio_m1_i (vd2_m1_i),
    .tc_o       (vd2_tc),
    .pulse_o    (vd2_en_o)
  );

  cdt_var_div3 #(.W(VD3_W)) u_vd3 (
    .clk        (clk),
    .rst        (rst),
    .src_vec_i  (src_vec),
    .src_sel_i  (vd3_src_i),
    .ratio_m1_i (vd3_m1_i),
    .en_o       (vd3_en_o)
  );

  AST_VD1_TC_TO_STROBE: assert property (@(posedge clk) disable iff (rst) vd1_tc |=> vd1_en_o); // R2
  AST_VD2_CHAIN: assert property (@(posedge clk) disable iff (rst) vd2_en_o |-> $past(vd1_en_o)); // R3
  AST_VD2_TC_TO_STROBE: assert property (@(posedge clk) disable iff (rst) vd2_tc |=> vd2_en_o); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !(cpu_en_o | vd1_en_o | vd2_en_o | vd3_en_o)); // R9
endmodule

// File: tb/cdt_clock_tree_bench.sv
`timescale 1ns/1ps
module cdt_clock_tree_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dbl_en_i = 1'b0;
  logic [2:0] cpu_sel = '0;
  logic [3:0] vd1_m1 = '0;
  logic [3:0] vd2_m1 = '0;
  logic [7:0] vd3_m1 = '0;
  logic [1:0] vd3_src = '0;
  logic       cpu_en, vd1_en, vd2_en, vd3_en;

  int  errs = 0;
  int  checks = 0;
  bit  done = 0;
  int  dbl_per = 3;

  always #2.5 clk = ~clk;

  cdt_clock_tree u_cdt_clock_tree (
    .clk       (clk),
    .rst       (rst),
    .dbl_en_i  (dbl_en_i),
    .cpu_sel_i (cpu_sel),
    .vd1_m1_i  (vd1_m1),
    .vd2_m1_i  (vd2_m1),
    .vd3_m1_i  (vd3_m1),
    .vd3_src_i (vd3_src),
    .cpu_en_o  (cpu_en),
    .vd1_en_o  (vd1_en),
    .vd2_en_o  (vd2_en),
    .vd3_en_o  (vd3_en)
  );

  // periodic double-rate enable, one pulse every dbl_per cycles
  initial begin
    int d;
    d = 0;
    forever begin
      @(negedge clk);
      dbl_en_i = (d == 0);
      d = (d + 1 >= dbl_per) ? 0 : d + 1;
    end
  end

  function automatic bit outsel(input int w);
    case (w)
      0: return cpu_en;
      1: return vd1_en;
      2: return vd2_en;
      default: return vd3_en;
    endcase
  endfunction

  function automatic int exp_period(input int w);
    int n1, n2, n3;
    n1 = vd1_m1 + 1; n2 = vd2_m1 + 1; n3 = vd3_m1 + 1;
    case (w)
      0: return 1 << cpu_sel;
      1: return n1;
      2: return n1 * n2;
      default: case (vd3_src)
        2'd0: return n3;
        2'd1: return n1 * n3;
        2'd2: return n1 * n2 * n3;
        default: return n3 * dbl_per;
      endcase
    endcase
  endfunction

  function automatic int exp_latency(input int w);
    int n1, n2, n3;
    n1 = vd1_m1 + 1; n2 = vd2_m1 + 1; n3 = vd3_m1 + 1;
    case (w)
      0: return 1 << cpu_sel;
      1: return n1;
      2: return n1 * n2 + 1;
      default: case (vd3_src)
        2'd0: return n3;
        2'd1: return n1 * n3 + 1;
        2'd2: return n1 * n2 * n3 + 2;
        default: return -1;
      endcase
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wait_pulse(input int w, output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!outsel(w));
  endtask

  task automatic measure(input int w, input string tag);
    int c, el;
    el = exp_latency(w);
    wait_pulse(w, c);
    if (el >= 0) chk(c == el, {tag, " R9 first pulse"}, c, el);
    wait_pulse(w, c);
    chk(c == exp_period(w), {tag, " period"}, c, exp_period(w));
  endtask

  initial begin
    int c, c2, rnd;
    rnd = $urandom(32'h0C1C_D1F0);
    // R9: reset holds outputs low
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({cpu_en, vd1_en, vd2_en, vd3_en} == 4'b0, "R9 outputs in reset", int'({cpu_en, vd1_en, vd2_en, vd3_en}), 0);
    rst = 1'b0;

    // R1 sweep of every code
    for (int s = 0; s < 8; s++) begin
      cpu_sel = 3'(s); do_reset(); measure(0, "R1 cpu");
    end
    // R2 sweep of every first-divider ratio
    for (int m = 0; m < 16; m++) begin
      vd1_m1 = 4'(m); do_reset(); measure(1, "R2 vd1");
    end
    // R3 sweep of second divider over two first-divider settings
    for (int a = 0; a < 2; a++) begin
      for (int m = 0; m < 16; m++) begin
        vd1_m1 = (a == 0) ? 4'd0 : 4'd2; vd2_m1 = 4'(m); do_reset(); measure(2, "R3 vd2");
      end
    end
    // R4 third divider, system source, low and high ratios
    vd3_src = 2'd0;
    for (int m = 0; m < 256; m++) begin
      if (m < 16 || m == 127 || m == 128 || m >= 254) begin
        vd3_m1 = 8'(m); do_reset(); measure(3, "R4 vd3 sys");
      end
    end
    // R5 every source
    vd1_m1 = 4'd2; vd2_m1 = 4'd1; vd3_m1 = 8'd4;
    for (int s = 0; s < 4; s++) begin
      vd3_src = 2'(s); do_reset(); measure(3, "R5 vd3 source");
    end
    // R6 unity ratio follows the input
    vd1_m1 = 4'd0; do_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(vd1_en == 1'b1, "R6 unity follows every cycle", int'(vd1_en), 1);
    end
    vd3_src = 2'd3; vd3_m1 = 8'd0; dbl_per = 3; do_reset(); measure(3, "R6 unity on double-rate source");
    // R7 single-cycle strobe
    vd1_m1 = 4'd3; do_reset(); wait_pulse(1, c);
    @(negedge clk);
    chk(vd1_en == 1'b0, "R7 strobe one cycle", int'(vd1_en), 0);
    // R8 ratio change mid-run
    vd1_m1 = 4'd4; do_reset(); wait_pulse(1, c);
    vd1_m1 = 4'd2;
    wait_pulse(1, c);  chk(c == 5, "R8 old ratio completes", c, 5);
    wait_pulse(1, c2); chk(c2 == 3, "R8 new ratio applies", c2, 3);
    // R8 source change mid-run
    vd1_m1 = 4'd1; vd3_src = 2'd0; vd3_m1 = 8'd3; do_reset(); wait_pulse(3, c);
    vd3_src = 2'd1;
    wait_pulse(3, c); chk(c == 4, "R8 old source completes", c, 4);
    wait_pulse(3, c);
    wait_pulse(3, c); chk(c == 8, "R8 new source applies", c, 8);

    // constrained random configurations
    for (int it = 0; it < 16; it++) begin
      cpu_sel = 3'($urandom % 8);
      vd1_m1  = 4'($urandom % 16);
      vd2_m1  = 4'($urandom % 16);
      vd3_src = 2'($urandom % 4);
      case (vd3_src)
        2'd0: vd3_m1 = 8'($urandom % 256);
        2'd1: vd3_m1 = 8'($urandom % 16);
        2'd2: begin vd1_m1 = 4'($urandom % 4); vd2_m1 = 4'($urandom % 4); vd3_m1 = 8'($urandom % 4); end
        default: begin vd3_m1 = 8'($urandom % 64); dbl_per = 1 + int'($urandom % 3); end
      endcase
      do_reset(); measure(3, "R4 R5 random vd3");
      do_reset(); measure(2, "R3 random vd2");
      do_reset(); measure(0, "R1 random cpu");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog R1..R9 hang: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule